// File: doc/BRIEF.md
# Timeout-Driven Power State Manager

This block decides the power state of one power-manageable component that can be running, idle (clock stopped, interrupts still watched) or asleep (all on-chip activity shut down). While the component runs, the block watches a request line. After a programmable stretch of cycles with no request, it walks the component down into idle. If idle then lasts beyond a break-even threshold, it shuts the component down into sleep. A wake interrupt or a new request brings the component back to run. A power-fault input forces the component toward sleep from any state.

Each edge of the state graph (run to idle, idle to run, into sleep, sleep to run) has its own programmable latency in ticks. The manager holds the component in a transition state for that long and raises its ready output only in run. Requests that arrive while the component is not running are latched and served once the component is back in run. The current state code and per-class cycle counters are exposed so that software or a monitor can estimate energy.

Top module: `pwr_state_mgr`

## Requirements
- R1: While reset is asserted and right after it, the state code is run (0), ready is high and all four cycle counters read zero.
- R2: In run, once the request line has been low for `idle_timeout_i` consecutive cycles (a value of 0 acts as 1), the block enters run-to-idle; any request cycle restarts that count.
- R3: Each transition state lasts max(L,1) cycles, where L is that edge's own latency input, and ready is low in every state other than run.
- R4: Sleep entry from idle starts only after idle has lasted T+1 cycles, where T = max(`break_even_i`, `lat_sleep_in_i` + `lat_sleep_out_i`), so the threshold is never below the total shutdown-plus-wakeup delay.
- R5: In idle with no fault, a wake interrupt or a request moves the block to idle-to-run at the next edge.
- R6: In sleep with no fault, a wake interrupt or a request moves the block to sleep-to-run at the next edge.
- R7: A power fault in any state other than shutdown or sleep moves the block to shutdown at the next edge; while the fault stays high, sleep ignores wake interrupts and requests.
- R8: A request seen during a transition is latched and, once the block settles in idle or sleep, returns it to run with no wake interrupt.
- R9: The counters `run_cyc_o`, `idle_cyc_o`, `sleep_cyc_o` and `trans_cyc_o` each add one for every clock spent in their class (any transition state counts as transition) and saturate at all ones.
- R10: The state code on `state_o` is run 0, run-to-idle 1, idle 2, idle-to-run 3, shutdown 4, sleep 5, sleep-to-run 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| activity_i | input | 1 | Request / activity from the served component |
| wake_irq_i | input | 1 | Wake interrupt |
| pwr_fault_i | input | 1 | Power fault, forces shutdown |
| idle_timeout_i | input | CW | Inactivity cycles before leaving run |
| break_even_i | input | CW | Requested break-even threshold in idle |
| lat_run_idle_i | input | CW | Run-to-idle latency |
| lat_idle_run_i | input | CW | Idle-to-run latency |
| lat_sleep_in_i | input | CW | Shutdown (into sleep) latency |
| lat_sleep_out_i | input | CW | Sleep-to-run latency |
| ready_o | output | 1 | Component can serve requests |
| state_o | output | 3 | Current state code |
| run_cyc_o | output | ACC_W | Cycles spent in run |
| idle_cyc_o | output | ACC_W | Cycles spent in idle |
| sleep_cyc_o | output | ACC_W | Cycles spent in sleep |
| trans_cyc_o | output | ACC_W | Cycles spent in transition states |

## Verification
The bench builds the block with CW = 8 and ACC_W = 6. The narrow tick width keeps every walk from run down to sleep and back within a few dozen cycles, so exact cycle counts for each latency and for the break-even floor are checked across several settings, including all-zero latencies. The six-bit counters let a hundred-cycle run stretch reach counter saturation.

// File: rtl/pwr_mgr_pkg.sv
package pwr_mgr_pkg;

   // State codes are visible on the state output (R10)
   typedef enum logic [2:0] {
      PS_RUN   = 3'd0,
      PS_R2I   = 3'd1,
      PS_IDLE  = 3'd2,
      PS_I2R   = 3'd3,
      PS_SHUT  = 3'd4,
      PS_SLEEP = 3'd5,
      PS_S2R   = 3'd6
   } pstate_e;

   // Accounting classes
   localparam int NUM_CLASS = 4;
   localparam int CL_RUN    = 0;
   localparam int CL_IDLE   = 1;
   localparam int CL_SLEEP  = 2;
   localparam int CL_TRANS  = 3;

endpackage

// File: rtl/pm_dwell_timer.sv
// Counts consecutive enabled cycles, clears when disabled, saturates.
module pm_dwell_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en_i,
   output logic [W-1:0] cnt_o
);
   localparam logic [W-1:0] MAXV = '1;

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)            cnt_q <= '0;
      else if (!en_i)        cnt_q <= '0;
      else if (cnt_q != MAXV) cnt_q <= cnt_q + W'(1);
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/pm_lat_counter.sv
// Transition latency counter: loading L makes zero_o rise after max(L,1)-1
// further cycles, so a transition state lasts max(L,1) cycles (R3).
module pm_lat_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] val_i,
   output logic         zero_o
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load_i)       cnt_q <= (val_i == '0) ? '0 : val_i - W'(1);
      else if (cnt_q != '0)  cnt_q <= cnt_q - W'(1);
   end

   assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pm_usage_acc.sv
// Per-class saturating cycle counters for energy estimation (R9).
module pm_usage_acc #(
   parameter int W   = 32,
   parameter int NCL = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NCL-1:0]          cls_i,
   output logic [NCL-1:0][W-1:0]   acc_o
);
   localparam logic [W-1:0] MAXV = '1;

   for (genvar g = 0; g < NCL; g++) begin : g_cls
      logic [W-1:0] acc_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                       acc_q <= '0;
         else if (cls_i[g] && acc_q != MAXV) acc_q <= acc_q + W'(1);
      end
      assign acc_o[g] = acc_q;
   end
endmodule

// File: rtl/pwr_state_mgr.sv
module pwr_state_mgr #(
   parameter int CW    = 16,
   parameter int ACC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             activity_i,
   input  logic             wake_irq_i,
   input  logic             pwr_fault_i,
   input  logic [CW-1:0]    idle_timeout_i,
   input  logic [CW-1:0]    break_even_i,
   input  logic [CW-1:0]    lat_run_idle_i,
   input  logic [CW-1:0]    lat_idle_run_i,
   input  logic [CW-1:0]    lat_sleep_in_i,
   input  logic [CW-1:0]    lat_sleep_out_i,
   output logic             ready_o,
   output logic [2:0]       state_o,
   output logic [ACC_W-1:0] run_cyc_o,
   output logic [ACC_W-1:0] idle_cyc_o,
   output logic [ACC_W-1:0] sleep_cyc_o,
   output logic [ACC_W-1:0] trans_cyc_o
);
   import pwr_mgr_pkg::*;

   localparam int TW = CW + 1;   // threshold width holds the latency sum

   if (CW < 2) begin : g_bad_cw
      $error("pwr_state_mgr: CW must be at least 2");
   end
   if (ACC_W < 2) begin : g_bad_acc
      $error("pwr_state_mgr: ACC_W must be at least 2");
   end

   pstate_e       state_q, state_d;
   logic          pend_q;
   logic          lat_load;
   logic [CW-1:0] lat_val;
   logic          lat_zero;
   logic [CW-1:0] inact_cnt;
   logic [TW-1:0] idle_cnt;
   logic [TW-1:0] lat_sum;
   logic [TW-1:0] sleep_thr;
   logic          wake_req;
   logic          inact_hit;
   logic          dwell_hit;

   // Break-even floor: never below shutdown plus wakeup delay (R4)
   assign lat_sum   = {1'b0, lat_sleep_in_i} + {1'b0, lat_sleep_out_i};
   assign sleep_thr = ({1'b0, break_even_i} > lat_sum) ? {1'b0, break_even_i} : lat_sum;

   pm_dwell_timer #(.W(CW)) u_inact (
      .clk   (clk),
      .rst_n (rst_n),
      .en_i  ((state_q == PS_RUN) && !activity_i),
      .cnt_o (inact_cnt)
   );

   pm_dwell_timer #(.W(TW)) u_idle (
      .clk   (clk),
      .rst_n (rst_n),
      .en_i  (state_q == PS_IDLE),
      .cnt_o (idle_cnt)
   );

   pm_lat_counter #(.W(CW)) u_lat (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (lat_load),
      .val_i  (lat_val),
      .zero_o (lat_zero)
   );

   // R2: timeout reached on this cycle of inactivity
   assign inact_hit = !activity_i &&
                      (({1'b0, inact_cnt} + TW'(1)) >= {1'b0, idle_timeout_i});
   // R4: idle strictly longer than the threshold
   assign dwell_hit = (idle_cnt + TW'(1)) > sleep_thr;
   assign wake_req  = wake_irq_i | activity_i | pend_q;

   always_comb begin
      state_d  = state_q;
      lat_load = 1'b0;
      lat_val  = '0;
      unique case (state_q)
         PS_RUN: begin
            if (pwr_fault_i) begin
               state_d = PS_SHUT;  lat_load = 1'b1; lat_val = lat_sleep_in_i;   // R7
            end else if (inact_hit) begin
               state_d = PS_R2I;   lat_load = 1'b1; lat_val = lat_run_idle_i;   // R2
            end
         end
         PS_R2I, PS_I2R, PS_S2R: begin
            if (pwr_fault_i) begin
               state_d = PS_SHUT;  lat_load = 1'b1; lat_val = lat_sleep_in_i;   // R7
            end else if (lat_zero) begin
               state_d = (state_q == PS_R2I) ? PS_IDLE : PS_RUN;                // R3
            end
         end
         PS_IDLE: begin
            if (pwr_fault_i) begin
               state_d = PS_SHUT;  lat_load = 1'b1; lat_val = lat_sleep_in_i;   // R7
            end else if (wake_req) begin
               state_d = PS_I2R;   lat_load = 1'b1; lat_val = lat_idle_run_i;   // R5 R8
            end else if (dwell_hit) begin
               state_d = PS_SHUT;  lat_load = 1'b1; lat_val = lat_sleep_in_i;   // R4
            end
         end
         PS_SHUT: begin
            if (lat_zero) state_d = PS_SLEEP;
         end
         PS_SLEEP: begin
            if (!pwr_fault_i && wake_req) begin
               state_d = PS_S2R;   lat_load = 1'b1; lat_val = lat_sleep_out_i;  // R6
            end
         end
         default: state_d = PS_RUN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= PS_RUN;
         pend_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         // R8: requests outside run are held until run is reached
         pend_q  <= (state_q == PS_RUN) ? 1'b0 : (pend_q | activity_i);
      end
   end

   // Energy accounting (R9)
   logic [NUM_CLASS-1:0]            cls;
   logic [NUM_CLASS-1:0][ACC_W-1:0] acc;

   always_comb begin
      cls = '0;
      unique case (state_q)
         PS_RUN:   cls[CL_RUN]   = 1'b1;
         PS_IDLE:  cls[CL_IDLE]  = 1'b1;
         PS_SLEEP: cls[CL_SLEEP] = 1'b1;
         default:  cls[CL_TRANS] = 1'b1;
      endcase
   end

   pm_usage_acc #(.W(ACC_W), .NCL(NUM_CLASS)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .cls_i (cls),
      .acc_o (acc)
   );

   assign run_cyc_o   = acc[CL_RUN];
   assign idle_cyc_o  = acc[CL_IDLE];
   assign sleep_cyc_o = acc[CL_SLEEP];
   assign trans_cyc_o = acc[CL_TRANS];

   assign ready_o = (state_q == PS_RUN);   // R3
   assign state_o = state_q;               // R10
endmodule

// File: rtl/pwr_state_mgr_chk.sv
module pwr_state_mgr_chk #(
   parameter int CW    = 16,
   parameter int ACC_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pwr_fault_i,
   input logic             wake_irq_i,
   input logic             ready_o,
   input logic [2:0]       state_o,
   input logic [ACC_W-1:0] run_cyc_o,
   input logic [CW:0]      idle_cnt,
   input logic [CW:0]      sleep_thr
);
   localparam logic [2:0] S_RUN = 3'd0, S_IDLE = 3'd2, S_I2R = 3'd3,
                          S_SHUT = 3'd4, S_SLEEP = 3'd5, S_S2R = 3'd6;

   logic in_sleep, in_shut;
   assign in_sleep = (state_o == S_SLEEP);
   assign in_shut  = (state_o == S_SHUT);

   AST_READY_AFTER_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready_o) |-> ($past(state_o) == S_I2R || $past(state_o) == S_S2R)); // R3

   AST_FAULT_SHUTS: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_fault_i |=> (state_o == S_SHUT || state_o == S_SLEEP)); // R7

   AST_SLEEP_VIA_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_sleep) |-> $past(state_o) == S_SHUT); // R3

   AST_BREAK_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(in_shut) && $past(state_o) == S_IDLE && !$past(pwr_fault_i))
      |-> ($past(idle_cnt) + 1'b1) > $past(sleep_thr)); // R4

   AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == S_IDLE && wake_irq_i && !pwr_fault_i) |=> state_o == S_I2R); // R5

   AST_FAULT_HOLDS_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (in_sleep && pwr_fault_i) |=> in_sleep); // R7

   AST_ACC_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
      run_cyc_o >= $past(run_cyc_o)); // R9

   AST_RUN_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == S_RUN) |-> ready_o); // R3
endmodule

bind pwr_state_mgr pwr_state_mgr_chk #(.CW(CW), .ACC_W(ACC_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pwr_fault_i (pwr_fault_i),
   .wake_irq_i  (wake_irq_i),
   .ready_o     (ready_o),
   .state_o     (state_o),
   .run_cyc_o   (run_cyc_o),
   .idle_cnt    (idle_cnt),
   .sleep_thr   (sleep_thr)
);

// File: tb/pwr_state_mgr_test.sv
`timescale 1ns/1ps
module pwr_state_mgr_test;
   localparam int CW    = 8;
   localparam int ACC_W = 6;

   localparam int ST_RUN = 0, ST_R2I = 1, ST_IDLE = 2, ST_I2R = 3,
                  ST_SHUT = 4, ST_SLEEP = 5, ST_S2R = 6;

   // {idle_timeout, run->idle, idle->run, sleep in, sleep out, break_even}
   localparam int VEC [0:3][0:5] = '{
      '{3, 2, 2, 4, 6, 20},
      '{2, 1, 3, 4, 6, 5},
      '{1, 0, 0, 0, 0, 0},
      '{5, 3, 1, 2, 3, 7}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic activity = 1'b0, wake = 1'b0, fault = 1'b0;
   logic [CW-1:0] tmo = '0, be = '0, l_ri = '0, l_ir = '0, l_si = '0, l_so = '0;
   logic ready;
   logic [2:0] state;
   logic [ACC_W-1:0] run_c, idle_c, sleep_c, trans_c;

   int total = 0;
   int fails = 0;

   always #4 clk = ~clk;

   pwr_state_mgr #(.CW(CW), .ACC_W(ACC_W)) uut (
      .clk(clk), .rst_n(rst_n), .activity_i(activity), .wake_irq_i(wake),
      .pwr_fault_i(fault), .idle_timeout_i(tmo), .break_even_i(be),
      .lat_run_idle_i(l_ri), .lat_idle_run_i(l_ir), .lat_sleep_in_i(l_si),
      .lat_sleep_out_i(l_so), .ready_o(ready), .state_o(state),
      .run_cyc_o(run_c), .idle_cyc_o(idle_c), .sleep_cyc_o(sleep_c),
      .trans_cyc_o(trans_c)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int atleast1(input int v);
      return (v == 0) ? 1 : v;
   endfunction

   function automatic int thr_of(input int b, input int si, input int so);
      return (b > si + so) ? b : si + so;
   endfunction

   task automatic set_cfg(input int t, input int ri, input int ir,
                          input int si, input int so, input int b);
      tmo = CW'(t); l_ri = CW'(ri); l_ir = CW'(ir);
      l_si = CW'(si); l_so = CW'(so); be = CW'(b);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wait_state(input int target, input int limit, inout int n);
      while (int'(state) != target && n < limit) begin
         @(negedge clk);
         n++;
      end
   endtask

   initial begin
      #(8 * 150000);
      total++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      int n;
      // ---- R1: reset state ----
      set_cfg(3, 2, 2, 4, 6, 20);
      activity = 1'b1;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(state == 3'(ST_RUN) && ready, "R1 state/ready in reset", int'(state), ST_RUN);
      chk(run_c == 0 && idle_c == 0 && sleep_c == 0 && trans_c == 0,
          "R1 counters in reset", int'(run_c) + int'(idle_c) + int'(sleep_c) + int'(trans_c), 0);
      rst_n = 1'b1;
      chk(state == 3'(ST_RUN) && ready, "R1 state after release", int'(state), ST_RUN);

      // ---- table walk: run -> idle -> sleep -> run ----
      for (int v = 0; v < 4; v++) begin
         int t, l1, ls, lr, th, k;
         set_cfg(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5]);
         activity = 1'b0;
         do_reset();
         t  = atleast1(VEC[v][0]);
         l1 = atleast1(VEC[v][1]);
         ls = atleast1(VEC[v][3]);
         lr = atleast1(VEC[v][4]);
         th = thr_of(VEC[v][5], VEC[v][3], VEC[v][4]);
         k  = t + l1 + th + 1 + ls;
         n = 0;
         wait_state(ST_SLEEP, 300, n);
         chk(n == k, "R4 cycles to sleep (R2 R3)", n, k);
         chk(int'(run_c) == t, "R2 run cycles before idle", int'(run_c), t);
         chk(int'(idle_c) == th + 1, "R4 idle dwell", int'(idle_c), th + 1);
         chk(int'(trans_c) == l1 + ls, "R9 transition cycles", int'(trans_c), l1 + ls);
         wake = 1'b1;
         @(negedge clk);
         wake = 1'b0;
         n = 1;
         chk(state == 3'(ST_S2R) && !ready, "R6 sleep-to-run entered, ready low",
             int'(state), ST_S2R);
         wait_state(ST_RUN, 300, n);
         chk(n == 1 + lr && ready, "R3 sleep-to-run latency", n, 1 + lr);
      end

      // ---- R2: requests restart the inactivity count ----
      set_cfg(4, 2, 3, 2, 2, 200);
      activity = 1'b1;
      do_reset();
      begin
         bit stayed;
         stayed = 1'b1;
         for (int i = 0; i < 12; i++) begin
            activity = (i % 3 == 2);
            @(negedge clk);
            if (state != 3'(ST_RUN)) stayed = 1'b0;
         end
         chk(stayed, "R2 periodic requests keep run", int'(state), ST_RUN);
      end
      activity = 1'b0;
      n = 0;
      wait_state(ST_R2I, 100, n);
      chk(n == 4, "R2 timeout after restart", n, 4);
      chk(!ready, "R3 ready low in run-to-idle", int'(ready), 0);

      // ---- R5: interrupt in idle ----
      wait_state(ST_IDLE, 100, n);
      repeat (5) @(negedge clk);
      chk(state == 3'(ST_IDLE), "R4 still idle below threshold", int'(state), ST_IDLE);
      wake = 1'b1;
      @(negedge clk);
      wake = 1'b0;
      chk(state == 3'(ST_I2R), "R5 idle wake, R10 code 3", int'(state), ST_I2R);
      n = 1;
      wait_state(ST_RUN, 100, n);
      chk(n == 4, "R5 idle-to-run latency", n, 4);

      // ---- R8: request during run-to-idle is held ----
      set_cfg(2, 4, 2, 2, 2, 200);
      activity = 1'b0;
      do_reset();
      n = 0;
      wait_state(ST_R2I, 100, n);
      activity = 1'b1;
      @(negedge clk);
      activity = 1'b0;
      n = 1;
      chk(state == 3'(ST_R2I), "R8 transition not cut short", int'(state), ST_R2I);
      wait_state(ST_RUN, 100, n);
      chk(n == 7, "R8 held request served", n, 7);

      // ---- R7: power fault ----
      set_cfg(50, 2, 2, 3, 2, 200);
      activity = 1'b1;
      do_reset();
      repeat (3) @(negedge clk);
      fault = 1'b1;
      @(negedge clk);
      chk(state == 3'(ST_SHUT) && !ready, "R7 fault enters shutdown", int'(state), ST_SHUT);
      n = 1;
      wait_state(ST_SLEEP, 100, n);
      chk(n == 4, "R7 shutdown latency", n, 4);
      wake = 1'b1;
      @(negedge clk);
      wake = 1'b0;
      @(negedge clk);
      chk(state == 3'(ST_SLEEP), "R7 wake ignored under fault", int'(state), ST_SLEEP);
      chk(int'(sleep_c) >= 2, "R9 sleep cycles counted", int'(sleep_c), 2);
      activity = 1'b0;
      fault = 1'b0;
      wake = 1'b1;
      @(negedge clk);
      wake = 1'b0;
      chk(state == 3'(ST_S2R), "R6 wake after fault clears", int'(state), ST_S2R);

      // ---- R9: saturation ----
      set_cfg(50, 2, 2, 3, 2, 200);
      activity = 1'b1;
      do_reset();
      repeat (100) @(negedge clk);
      chk(int'(run_c) == 63, "R9 run counter saturates", int'(run_c), 63);
      chk(int'(idle_c) == 0 && int'(trans_c) == 0, "R9 other classes idle",
          int'(idle_c) + int'(trans_c), 0);

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule